// File: doc/BRIEF.md
# Scalar/Vector Shared Data Port Arbiter

This block puts one 32-bit data memory port behind two requesters: a scalar core and a vector coprocessor. It picks at most one request per cycle and passes that request's command fields to memory. It records the owner of every granted request and sends each in-order memory response back to that owner.

The block also enforces ordering between the two sides. The vector unit signals, with a one-cycle pulse, each load or store instruction it takes on. The pulse itself already blocks scalar requests. The vector unit tags the final memory request of each instruction as its last. Scalar requests stay blocked until the response to the last request of every such instruction has come back. Because the block starts from the instruction pulse and not from the first vector request, a scalar load placed directly after a vector store can never reach memory ahead of that store.

Top module: `mem_order_arb`

## Requirements
- R1: After reset, no grant is given, neither response valid is high and the pending indication is low.
- R2: At most one of the two grants is high in any cycle. A grant is given only in a cycle where the memory port signals grant. The memory command (request, write enable, address, write data, byte enables) comes from the side that was selected.
- R3: When both sides request, the block is not holding the scalar side and there is room to track the request, the vector side is selected. The scalar request is served in a later cycle.
- R4: In the cycle the vector instruction pulse is high, the pending indication is already high. A scalar request in that cycle is neither granted nor forwarded to memory.
- R5: The pending indication stays high as long as any instruction announced by the pulse has not returned its last response. With two instructions announced, it stays high after the first one finishes.
- R6: The pending indication falls in the cycle after the response to the last request of the final open vector instruction. A waiting scalar request is granted in that same cycle.
- R7: Each memory response is raised on the valid output of the side that owns the oldest outstanding request, and its read data is passed through unchanged. The other side's response valid stays low.
- R8: A scalar load to an address that a preceding vector store wrote returns the stored data.
- R9: The memory request is withheld while the owner-tag queue holds its maximum number of outstanding requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_req | input | 1 | Scalar request |
| sc_we | input | 1 | Scalar write enable |
| sc_addr | input | AW | Scalar byte address |
| sc_wdata | input | DW | Scalar write data |
| sc_be | input | DW/8 | Scalar byte enables |
| sc_gnt | output | 1 | Scalar request accepted |
| sc_rvalid | output | 1 | Response for scalar side |
| sc_rdata | output | DW | Scalar read data |
| vc_accept | input | 1 | Pulse: vector unit took on a memory instruction |
| vc_req | input | 1 | Vector request |
| vc_we | input | 1 | Vector write enable |
| vc_addr | input | AW | Vector byte address |
| vc_wdata | input | DW | Vector write data |
| vc_be | input | DW/8 | Vector byte enables |
| vc_last | input | 1 | Request is the final one of its instruction |
| vc_gnt | output | 1 | Vector request accepted |
| vc_rvalid | output | 1 | Response for vector side |
| vc_rdata | output | DW | Vector read data |
| vc_pending | output | 1 | Vector memory work open; scalar side held |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_be | output | DW/8 | Memory byte enables |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Memory response, in request order |
| mem_rdata | input | DW | Memory read data |

## Verification
The checker assumes that memory returns exactly one response per granted request, in grant order. It also assumes that the vector unit ends every announced instruction with one request tagged last, and that the number of open instructions never exceeds the tracker's count. The bench memory model answers every accepted request one cycle later and never reorders responses. The directed vector sequences always tag their final request and never announce more than two instructions at once, so the stimulus stays inside these limits.

// File: rtl/mem_order_arb_pkg.sv
package mem_order_arb_pkg;

    typedef enum logic {
        OWN_SCALAR = 1'b0,
        OWN_VECTOR = 1'b1
    } owner_e;

    // Bookkeeping carried for every granted request until its response returns
    typedef struct packed {
        owner_e owner;
        logic   last;
    } owner_tag_t;

endpackage

// File: rtl/arb_tag_fifo.sv
module arb_tag_fifo
    import mem_order_arb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  owner_tag_t tag_i,
    input  logic       pop_i,
    output owner_tag_t head_o,
    output logic       full_o,
    output logic       empty_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]       wr;
        logic [PTR_W-1:0]       rd;
        logic [CNT_W-1:0]       cnt;
        owner_tag_t [DEPTH-1:0] slot;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full_o  = (st_q.cnt == CNT_MAX);
    assign empty_o = (st_q.cnt == '0);
    assign head_o  = st_q.slot[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && !empty_o;
        do_push = push_i && (!full_o || do_pop);
        if (do_push) begin
            st_d.slot[st_q.wr] = tag_i;
            st_d.wr = (st_q.wr == PTR_MAX) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_MAX) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/arb_pend_track.sv
module arb_pend_track #(
    parameter int unsigned CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic pending_o
);
    typedef struct packed {
        logic [CNT_W-1:0] open_cnt;
    } pend_st_t;

    pend_st_t st_d, st_q;

    // High from the very cycle an instruction is announced
    assign pending_o = (st_q.open_cnt != '0) || open_i;

    always_comb begin
        st_d = st_q;
        case ({open_i, close_i})
            2'b10:   st_d.open_cnt = st_q.open_cnt + 1'b1;
            2'b01:   st_d.open_cnt = st_q.open_cnt - 1'b1;
            default: st_d.open_cnt = st_q.open_cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick (
    input  logic vec_req_i,
    input  logic sca_req_i,
    input  logic sca_hold_i,
    input  logic room_i,
    input  logic mem_gnt_i,
    output logic pick_vec_o,
    output logic pick_sca_o,
    output logic gnt_vec_o,
    output logic gnt_sca_o
);
    always_comb begin
        pick_vec_o = room_i && vec_req_i;
        pick_sca_o = room_i && !vec_req_i && sca_req_i && !sca_hold_i;
        gnt_vec_o  = pick_vec_o && mem_gnt_i;
        gnt_sca_o  = pick_sca_o && mem_gnt_i;
    end
endmodule

// File: rtl/mem_order_arb.sv
module mem_order_arb
    import mem_order_arb_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned TAG_DEPTH = 4,
    parameter int unsigned OPEN_W    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sc_req,
    input  logic            sc_we,
    input  logic [AW-1:0]   sc_addr,
    input  logic [DW-1:0]   sc_wdata,
    input  logic [DW/8-1:0] sc_be,
    output logic            sc_gnt,
    output logic            sc_rvalid,
    output logic [DW-1:0]   sc_rdata,
    input  logic            vc_accept,
    input  logic            vc_req,
    input  logic            vc_we,
    input  logic [AW-1:0]   vc_addr,
    input  logic [DW-1:0]   vc_wdata,
    input  logic [DW/8-1:0] vc_be,
    input  logic            vc_last,
    output logic            vc_gnt,
    output logic            vc_rvalid,
    output logic [DW-1:0]   vc_rdata,
    output logic            vc_pending,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW/8-1:0] mem_be,
    input  logic            mem_gnt,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata
);
    logic       pick_vec, pick_sca, tag_full, tag_empty, resp_vec, last_done;
    owner_tag_t push_tag, head_tag;

    arb_pick u_pick (
        .vec_req_i  (vc_req),
        .sca_req_i  (sc_req),
        .sca_hold_i (vc_pending),
        .room_i     (!tag_full),
        .mem_gnt_i  (mem_gnt),
        .pick_vec_o (pick_vec),
        .pick_sca_o (pick_sca),
        .gnt_vec_o  (vc_gnt),
        .gnt_sca_o  (sc_gnt)
    );

    assign push_tag.owner = pick_vec ? OWN_VECTOR : OWN_SCALAR;
    assign push_tag.last  = pick_vec && vc_last;

    arb_tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (vc_gnt || sc_gnt),
        .tag_i   (push_tag),
        .pop_i   (mem_rvalid),
        .head_o  (head_tag),
        .full_o  (tag_full),
        .empty_o (tag_empty)
    );

    assign resp_vec  = mem_rvalid && !tag_empty && (head_tag.owner == OWN_VECTOR);
    assign last_done = resp_vec && head_tag.last;

    arb_pend_track #(.CNT_W(OPEN_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (vc_accept),
        .close_i   (last_done),
        .pending_o (vc_pending)
    );

    always_comb begin
        mem_req   = pick_vec || pick_sca;
        mem_we    = pick_vec ? vc_we    : sc_we;
        mem_addr  = pick_vec ? vc_addr  : sc_addr;
        mem_wdata = pick_vec ? vc_wdata : sc_wdata;
        mem_be    = pick_vec ? vc_be    : sc_be;
        vc_rvalid = resp_vec;
        sc_rvalid = mem_rvalid && !tag_empty && (head_tag.owner == OWN_SCALAR);
        vc_rdata  = mem_rdata;
        sc_rdata  = mem_rdata;
    end
endmodule

// File: rtl/mem_order_arb_chk.sv
module mem_order_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic sc_req,
    input logic sc_gnt,
    input logic sc_rvalid,
    input logic vc_accept,
    input logic vc_req,
    input logic vc_gnt,
    input logic vc_rvalid,
    input logic vc_pending,
    input logic mem_req,
    input logic mem_gnt,
    input logic mem_rvalid,
    input logic tag_full
);
    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_gnt && vc_gnt));

    // R2
    gnt_needs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_gnt || vc_gnt) |-> (mem_req && mem_gnt));

    // R3
    vec_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_gnt |-> (sc_req && !vc_req));

    // R4
    hold_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vc_pending |-> !sc_gnt);

    // R4
    announce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vc_accept |-> vc_pending);

    // R6
    clear_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vc_pending) |-> $past(vc_rvalid));

    // R7
    single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_rvalid && vc_rvalid));

    // R7
    route_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_rvalid || vc_rvalid) |-> mem_rvalid);

    // R9
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_full && !mem_rvalid) |-> !mem_req);
endmodule

bind mem_order_arb mem_order_arb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_req     (sc_req),
    .sc_gnt     (sc_gnt),
    .sc_rvalid  (sc_rvalid),
    .vc_accept  (vc_accept),
    .vc_req     (vc_req),
    .vc_gnt     (vc_gnt),
    .vc_rvalid  (vc_rvalid),
    .vc_pending (vc_pending),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .tag_full   (tag_full)
);

// File: tb/mem_order_arb_test.sv
module mem_order_arb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sc_req = 0, sc_we = 0;
    logic [31:0] sc_addr = 0, sc_wdata = 0;
    logic [3:0]  sc_be = 4'hF;
    logic        sc_gnt, sc_rvalid;
    logic [31:0] sc_rdata;
    logic        vc_accept = 0, vc_req = 0, vc_we = 0, vc_last = 0;
    logic [31:0] vc_addr = 0, vc_wdata = 0;
    logic [3:0]  vc_be = 4'hF;
    logic        vc_gnt, vc_rvalid, vc_pending;
    logic [31:0] vc_rdata;
    logic        mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        gnt_en = 1'b1;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_order_arb uut (.*);

    // Memory model: accepts when enabled, answers one cycle later, in order
    logic [31:0] store [16];
    logic        rv_q;
    logic [31:0] rd_q;
    assign mem_gnt    = gnt_en;
    assign mem_rvalid = rv_q;
    assign mem_rdata  = rd_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
            rd_q <= '0;
            for (int i = 0; i < 16; i++) store[i] <= '0;
        end else if (mem_req && mem_gnt) begin
            rv_q <= 1'b1;
            rd_q <= mem_we ? 32'h0 : store[mem_addr[5:2]];
            if (mem_we) store[mem_addr[5:2]] <= mem_wdata;
        end else begin
            rv_q <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sc_req = 0; vc_req = 0; vc_accept = 0; vc_last = 0; sc_we = 0; vc_we = 0;
    endtask

    task automatic t_reset();
        #1;
        check(!sc_gnt && !vc_gnt, "R1 grants", {sc_gnt, vc_gnt}, 0);
        check(!sc_rvalid && !vc_rvalid, "R1 rvalid", {sc_rvalid, vc_rvalid}, 0);
        check(!vc_pending, "R1 pending", vc_pending, 0);
    endtask

    task automatic t_scalar();
        next_cycle();
        sc_req = 1; sc_we = 1; sc_addr = 32'h10; sc_wdata = 32'hA5A5_0001; #1;
        check(sc_gnt && mem_we && mem_addr == 32'h10 && mem_wdata == 32'hA5A5_0001,
              "R2 scalar command", mem_addr, 32'h10);
        next_cycle();
        sc_we = 0; #1;
        check(sc_rvalid && !vc_rvalid, "R7 scalar write response", {sc_rvalid, vc_rvalid}, 2);
        next_cycle();
        idle(); #1;
        check(sc_rvalid && sc_rdata == 32'hA5A5_0001, "R7 scalar read data", sc_rdata, 32'hA5A5_0001);
    endtask

    task automatic t_prio();
        next_cycle();
        vc_req = 1; vc_we = 1; vc_addr = 32'h20; vc_wdata = 32'h0000_BEEF;
        sc_req = 1; sc_we = 0; sc_addr = 32'h20; #1;
        check(vc_gnt && !sc_gnt && mem_addr == 32'h20 && mem_wdata == 32'hBEEF,
              "R3 vector wins", {vc_gnt, sc_gnt}, 2);
        next_cycle();
        vc_req = 0; #1;
        check(sc_gnt && !vc_gnt, "R3 scalar served later", {vc_gnt, sc_gnt}, 1);
        check(vc_rvalid && !sc_rvalid, "R7 vector response", {vc_rvalid, sc_rvalid}, 2);
        next_cycle();
        idle(); #1;
        check(sc_rvalid && sc_rdata == 32'hBEEF, "R7 scalar read after vector write",
              sc_rdata, 32'hBEEF);
    endtask

    task automatic t_store_order();
        next_cycle();
        vc_accept = 1; sc_req = 1; sc_we = 0; sc_addr = 32'h30; #1;
        check(vc_pending && !sc_gnt && !mem_req, "R4 hold in announce cycle",
              {vc_pending, sc_gnt, mem_req}, 3'b100);
        next_cycle();
        vc_accept = 0; vc_req = 1; vc_we = 1; vc_addr = 32'h30; vc_wdata = 32'h1234_5678;
        vc_last = 0; #1;
        check(vc_gnt && !sc_gnt, "R4 scalar held, first store", {vc_gnt, sc_gnt}, 2);
        next_cycle();
        vc_addr = 32'h34; vc_wdata = 32'h0000_9ABC; vc_last = 1; #1;
        check(vc_gnt && !sc_gnt, "R4 scalar held, last store", {vc_gnt, sc_gnt}, 2);
        next_cycle();
        vc_req = 0; vc_last = 0; #1;
        check(vc_pending && !sc_gnt && vc_rvalid, "R6 held until last response returns",
              {vc_pending, sc_gnt, vc_rvalid}, 3'b101);
        next_cycle();
        #1;
        check(!vc_pending && sc_gnt, "R6 released after last response",
              {vc_pending, sc_gnt}, 1);
        next_cycle();
        idle(); #1;
        check(sc_rvalid && sc_rdata == 32'h1234_5678, "R8 load sees vector store",
              sc_rdata, 32'h1234_5678);
    endtask

    task automatic t_two_instr();
        next_cycle();
        vc_accept = 1; #1;
        next_cycle();
        vc_req = 1; vc_we = 0; vc_addr = 32'h30; vc_last = 1; #1;
        check(vc_gnt, "R5 first load granted", vc_gnt, 1);
        next_cycle();
        vc_accept = 0; vc_addr = 32'h34; #1;
        check(vc_pending && vc_rvalid && vc_rdata == 32'h1234_5678,
              "R5 pending after first instruction ends", vc_rdata, 32'h1234_5678);
        next_cycle();
        vc_req = 0; vc_last = 0; #1;
        check(vc_pending && vc_rvalid && vc_rdata == 32'h9ABC,
              "R7 second vector load data", vc_rdata, 32'h9ABC);
        next_cycle();
        #1;
        check(!vc_pending, "R5 pending clears after both", vc_pending, 0);
        idle();
    endtask

    task automatic t_mem_stall();
        next_cycle();
        gnt_en = 0; sc_req = 1; sc_we = 0; sc_addr = 32'h10; #1;
        check(mem_req && !sc_gnt && !vc_gnt, "R2 no grant without memory grant",
              {mem_req, sc_gnt}, 2);
        next_cycle();
        gnt_en = 1; #1;
        check(sc_gnt, "R2 grant once memory accepts", sc_gnt, 1);
        next_cycle();
        idle(); #1;
        check(sc_rvalid && sc_rdata == 32'hA5A5_0001, "R7 data after stall", sc_rdata, 32'hA5A5_0001);
    endtask

    task automatic t_full();
        // Withhold responses so four requests fill the tag queue
        next_cycle();
        gnt_en = 1; sc_req = 1; sc_we = 0; sc_addr = 32'h0;
        force mem_rvalid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(sc_gnt, "R9 fill tag queue", sc_gnt, 1);
            next_cycle();
        end
        #1;
        check(!mem_req && !sc_gnt, "R9 queue full withholds request", {mem_req, sc_gnt}, 0);
        idle();
        release mem_rvalid;
        rst_n = 0;
        next_cycle();
        rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_scalar();
        t_prio();
        t_store_order();
        t_two_instr();
        t_mem_stall();
        t_full();
        next_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired before all scenarios finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule